// File: doc/BRIEF.md
# I2C Serial Clock Timing Generator

This block paces the serial clock of an I2C master for standard and fast speed classes. Every clock period is split into a driven-low part and a released part, and both are measured in system clock cycles. The length comes from a programmed baud count. In standard mode the low and high parts each last one baud count, so one period is two baud counts. In fast mode the low part lasts two baud counts and the high part one, so one period is three baud counts. Speed codes above fast fall back to standard timing. A baud count of zero holds the generator idle.

The block watches the sensed clock line. A slave may hold the line low after the master has released it. While that happens the released part does not advance, and the count restarts once the line reads high. When the released part was stretched in this way, it is lengthened by a programmable setup count, which gives data time to settle. The bit engine gets three single-cycle strobes: one at the start of each low part, one when the line is released, and one at the midpoint of the low part, where data may change. Pulling the enable low parks the clock released and clears all counting.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is asserted or `enable` is low, `scl_out` is 1 and all three strobes are 0. In the cycle after the first clock edge that samples `enable` high (with a non-zero baud count), the clock is in the first cycle of a low part, with `scl_out` 0 and `low_strobe` 1.
- R2: With `speed_mode` = 0 (standard), every low part lasts `baud_cnt` cycles and every unstretched high part lasts `baud_cnt` cycles.
- R3: With `speed_mode` = 1 (fast), every low part lasts 2×`baud_cnt` cycles and every unstretched high part lasts `baud_cnt` cycles.
- R4: With `speed_mode` = 2 or 3, the timing is identical to standard mode.
- R5: While `baud_cnt` is 0, `scl_out` stays 1 and no strobe is produced. A non-zero value restarts with a low part in the cycle after the edge that samples it.
- R6: During a high part, every cycle in which `scl_in` is low holds the phase count at zero, so no low part begins. Counting of the high part starts over once `scl_in` reads high.
- R7: A high part that saw `scl_in` low lasts `baud_cnt` + `setup_cnt` cycles of `scl_in` high, counted from the release of the line. A high part that was never held is not lengthened by `setup_cnt`.
- R8: `low_strobe` is 1 in exactly the first cycle of each low part. `high_strobe` is 1 in exactly the first cycle of each high part. The two are never 1 together.
- R9: `data_strobe` is 1 in the cycle of the low part whose zero-based index equals floor(low length / 2).
- R10: Pulling `enable` low in the middle of a period makes `scl_out` 1 with all strobes 0 from the cycle after the edge that samples it. The next enable starts a fresh low part.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Peripheral enable; low parks the clock released |
| speed_mode | input | 2 | 0 standard, 1 fast, 2 and 3 treated as standard |
| baud_cnt | input | 16 | Baud count in system cycles; 0 keeps the generator idle |
| setup_cnt | input | 16 | Extra released cycles after a stretched high part |
| scl_in | input | 1 | Sensed level of the serial clock line |
| scl_out | output | 1 | Clock drive: 0 pulls the line low, 1 releases it |
| low_strobe | output | 1 | First cycle of a low part |
| high_strobe | output | 1 | First cycle of a high part |
| data_strobe | output | 1 | Midpoint of the low part, where data may change |

## Verification
The assertions assume that `scl_in` is the wired-AND of `scl_out` and the slave's hold. The line can read low while the master releases it, but it never reads high while `scl_out` is 0. The bench builds `scl_in` as exactly that AND of the generator's own drive and a slave-hold signal. It raises the hold only after a `high_strobe` has been seen. Configuration inputs change only between clock edges, half a period after the sampling edge, so each edge sees one stable setting. Speed, baud and setup changes made while running are allowed, since the reference model re-reads them every cycle as the design does.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_t;

  localparam logic [1:0] MODE_STD  = 2'd0;
  localparam logic [1:0] MODE_FAST = 2'd1;

endpackage

// File: rtl/scl_span_calc.sv
module scl_span_calc
  import scl_timing_pkg::*;
#(
  parameter int BAUD_W  = 16,
  parameter int SETUP_W = 16,
  parameter int CW      = 18
) (
  input  logic [1:0]         speed_mode,
  input  logic [BAUD_W-1:0]  baud,
  input  logic [SETUP_W-1:0] setup,
  output logic [CW-1:0]      low_span,
  output logic [CW-1:0]      high_span,
  output logic [CW-1:0]      settle_span,
  output logic [CW-1:0]      mid_point,
  output logic               baud_ok
);

  // Only code 1 selects the three-part period; every other code falls back.
  function automatic logic pick_fast(input logic [1:0] m);
    return (m == MODE_FAST);
  endfunction

  function automatic logic [CW-1:0] span_low(input logic [BAUD_W-1:0] b,
                                             input logic f);
    return f ? (CW'(b) << 1) : CW'(b);
  endfunction

  function automatic logic [CW-1:0] span_settle(input logic [BAUD_W-1:0] b,
                                                input logic [SETUP_W-1:0] s);
    return CW'(b) + CW'(s);
  endfunction

  logic fast_sel;

  always_comb begin
    fast_sel    = pick_fast(speed_mode);
    low_span    = span_low(baud, fast_sel);
    high_span   = CW'(baud);
    settle_span = span_settle(baud, setup);
    mid_point   = low_span >> 1;
    baud_ok     = (baud != '0);
  end

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_timing_pkg::*;
#(
  parameter int CW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          line_hi,
  input  logic [CW-1:0] low_span,
  input  logic [CW-1:0] high_span,
  input  logic [CW-1:0] settle_span,
  output phase_t        phase_q,
  output logic [CW-1:0] cnt_q,
  output logic          stretched_q,
  output logic          low_end,
  output logic          high_end,
  output logic          hold_evt
);

  phase_t        ph_d;
  logic [CW-1:0] cnt_d;
  logic          str_d;
  logic [CW-1:0] high_goal;

  // Named events for the checker and for readability.
  always_comb begin
    high_goal = stretched_q ? settle_span : high_span;
    low_end   = (phase_q == PH_LOW) && (cnt_q >= low_span - CW'(1));
    hold_evt  = (phase_q == PH_HIGH) && !line_hi;
    high_end  = (phase_q == PH_HIGH) && line_hi && (cnt_q >= high_goal - CW'(1));
  end

  always_comb begin
    ph_d  = phase_q;
    cnt_d = cnt_q;
    str_d = stretched_q;
    if (!run) begin
      ph_d  = PH_IDLE;
      cnt_d = '0;
      str_d = 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          ph_d  = PH_LOW;
          cnt_d = '0;
          str_d = 1'b0;
        end
        PH_LOW: begin
          if (low_end) begin
            ph_d  = PH_HIGH;
            cnt_d = '0;
            str_d = 1'b0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        PH_HIGH: begin
          if (hold_evt) begin
            cnt_d = '0;
            str_d = 1'b1;
          end else if (high_end) begin
            ph_d  = PH_LOW;
            cnt_d = '0;
            str_d = 1'b0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        default: begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
          str_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      cnt_q       <= '0;
      stretched_q <= 1'b0;
    end else begin
      phase_q     <= ph_d;
      cnt_q       <= cnt_d;
      stretched_q <= str_d;
    end
  end

endmodule

// File: rtl/scl_strobe_gen.sv
module scl_strobe_gen
  import scl_timing_pkg::*;
#(
  parameter int CW = 18
) (
  input  phase_t        phase_q,
  input  logic [CW-1:0] cnt_q,
  input  logic          stretched_q,
  input  logic [CW-1:0] mid_point,
  output logic          scl_drive,
  output logic          low_pulse,
  output logic          high_pulse,
  output logic          data_pulse
);

  always_comb begin
    scl_drive  = (phase_q != PH_LOW);
    low_pulse  = (phase_q == PH_LOW) && (cnt_q == '0);
    high_pulse = (phase_q == PH_HIGH) && (cnt_q == '0) && !stretched_q;
    data_pulse = (phase_q == PH_LOW) && (cnt_q == mid_point);
  end

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int BAUD_W  = 16,
  parameter int SETUP_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [1:0]         speed_mode,
  input  logic [BAUD_W-1:0]  baud_cnt,
  input  logic [SETUP_W-1:0] setup_cnt,
  input  logic               scl_in,
  output logic               scl_out,
  output logic               low_strobe,
  output logic               high_strobe,
  output logic               data_strobe
);

  // Room for twice the baud count and for baud plus setup, with one spare bit.
  localparam int SPAN_W = (BAUD_W + 1 > SETUP_W) ? BAUD_W + 1 : SETUP_W;
  localparam int CW     = SPAN_W + 1;

  logic [CW-1:0] low_span;
  logic [CW-1:0] high_span;
  logic [CW-1:0] settle_span;
  logic [CW-1:0] mid_point;
  logic          baud_ok;
  logic          run;
  phase_t        phase_q;
  logic [CW-1:0] cnt_q;
  logic          stretched_q;
  logic          low_end;
  logic          high_end;
  logic          hold_evt;

  assign run = enable && baud_ok;

  scl_span_calc #(
    .BAUD_W (BAUD_W),
    .SETUP_W(SETUP_W),
    .CW     (CW)
  ) u_span (
    .speed_mode (speed_mode),
    .baud       (baud_cnt),
    .setup      (setup_cnt),
    .low_span   (low_span),
    .high_span  (high_span),
    .settle_span(settle_span),
    .mid_point  (mid_point),
    .baud_ok    (baud_ok)
  );

  scl_phase_fsm #(
    .CW(CW)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .line_hi    (scl_in),
    .low_span   (low_span),
    .high_span  (high_span),
    .settle_span(settle_span),
    .phase_q    (phase_q),
    .cnt_q      (cnt_q),
    .stretched_q(stretched_q),
    .low_end    (low_end),
    .high_end   (high_end),
    .hold_evt   (hold_evt)
  );

  scl_strobe_gen #(
    .CW(CW)
  ) u_strobe (
    .phase_q    (phase_q),
    .cnt_q      (cnt_q),
    .stretched_q(stretched_q),
    .mid_point  (mid_point),
    .scl_drive  (scl_out),
    .low_pulse  (low_strobe),
    .high_pulse (high_strobe),
    .data_pulse (data_strobe)
  );

endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk
  import scl_timing_pkg::*;
#(
  parameter int BAUD_W = 16,
  parameter int CW     = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [BAUD_W-1:0] baud_cnt,
  input logic              scl_in,
  input logic              scl_out,
  input logic              low_strobe,
  input logic              high_strobe,
  input logic              data_strobe,
  input phase_t            phase_q,
  input logic [CW-1:0]     cnt_q
);

  assert_park_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (scl_out && !low_strobe && !high_strobe && !data_strobe));

  assert_zero_baud_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_cnt == '0) |=> scl_out);

  assert_stretch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_HIGH) && !scl_in && enable && (baud_cnt != '0))
      |=> ((phase_q == PH_HIGH) && (cnt_q == '0)));

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({low_strobe, high_strobe}));

  assert_high_after_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    high_strobe |-> !$past(scl_out));

endmodule

bind scl_timing_gen scl_timing_chk #(
  .BAUD_W(BAUD_W),
  .CW    (CW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .baud_cnt   (baud_cnt),
  .scl_in     (scl_in),
  .scl_out    (scl_out),
  .low_strobe (low_strobe),
  .high_strobe(high_strobe),
  .data_strobe(data_strobe),
  .phase_q    (phase_q),
  .cnt_q      (cnt_q)
);

// File: tb/sim_scl_timing_gen.sv
`timescale 1ns/1ps
module sim_scl_timing_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [15:0] baud = 16'd3;
  logic [15:0] setup = 16'd0;
  logic        hold = 1'b0;
  logic        scl_line;
  logic        scl_out, low_strobe, high_strobe, data_strobe;

  int    checks = 0;
  int    failures = 0;
  int    cyc = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  // Wired-AND of the master drive and the slave hold.
  assign scl_line = scl_out & ~hold;

  scl_timing_gen u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .speed_mode (mode),
    .baud_cnt   (baud),
    .setup_cnt  (setup),
    .scl_in     (scl_line),
    .scl_out    (scl_out),
    .low_strobe (low_strobe),
    .high_strobe(high_strobe),
    .data_strobe(data_strobe)
  );

  // ---------------- behavioural reference ----------------
  int m_state = 0;   // 0 parked, 1 pulling low, 2 released
  int m_pos = 0;
  bit m_held = 0;

  function automatic int ref_low_len();
    return (mode == 2'd1) ? 2 * int'(baud) : int'(baud);
  endfunction

  always @(posedge clk) begin
    int  lo;
    int  goal;
    bit  line;
    lo   = ref_low_len();
    goal = int'(baud) + (m_held ? int'(setup) : 0);
    line = (m_state != 1) && !hold;
    if (!rst_n || !enable || baud == 16'd0) begin
      m_state = 0; m_pos = 0; m_held = 0;
    end else if (m_state == 0) begin
      m_state = 1; m_pos = 0; m_held = 0;
    end else if (m_state == 1) begin
      if (m_pos + 1 >= lo) begin m_state = 2; m_pos = 0; m_held = 0; end
      else m_pos++;
    end else begin
      if (!line) begin m_pos = 0; m_held = 1; end
      else if (m_pos + 1 >= goal) begin m_state = 1; m_pos = 0; m_held = 0; end
      else m_pos++;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_scl, e_lo, e_hi, e_dat;
      e_scl = (m_state != 1);
      e_lo  = (m_state == 1) && (m_pos == 0);
      e_hi  = (m_state == 2) && (m_pos == 0) && !m_held;
      e_dat = (m_state == 1) && (m_pos == ref_low_len() / 2);
      chk({scl_out, low_strobe, high_strobe, data_strobe} == {e_scl, e_lo, e_hi, e_dat},
          {cur_req, " per-cycle model"},
          {scl_out, low_strobe, high_strobe, data_strobe}, {e_scl, e_lo, e_hi, e_dat});
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=finished", cyc);
      summary();
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic set_cfg(input logic [1:0] m, input int b, input int s);
    @(negedge clk); #1;
    mode = m; baud = 16'(b); setup = 16'(s);
  endtask

  task automatic wait_low_start();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (low_strobe) break;
    end
  endtask

  task automatic wait_high_start();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (high_strobe) break;
    end
  endtask

  // Measures one whole period from a low_strobe to the next one.
  task automatic check_period(input int lexp, input int hexp, input string tag);
    int nl = 0, nh = 0, didx = -1;
    bit first_hi = 0, seen_hi = 0;
    wait_low_start();
    for (int i = 0; i < 3000 && !scl_out; i++) begin
      if (data_strobe && didx < 0) didx = nl;
      nl++;
      @(negedge clk);
    end
    for (int i = 0; i < 3000 && !low_strobe; i++) begin
      if (!seen_hi) begin first_hi = high_strobe; seen_hi = 1; end
      nh++;
      @(negedge clk);
    end
    chk(nl == lexp, {tag, " low length"}, nl, lexp);
    chk(nh == hexp, {tag, " high length"}, nh, hexp);
    chk(didx == lexp / 2, "R9 data strobe index", didx, lexp / 2);
    chk(first_hi, "R8 high strobe on first released cycle", first_hi, 1);
  endtask

  // Holds the line after a release and counts released cycles until the next low part.
  task automatic stretch_run(input int hold_cycles, input int exp_after, input string tag);
    bit saw_low = 0;
    int n;
    wait_high_start();
    #1 hold = 1'b1;
    for (int i = 0; i < hold_cycles; i++) begin
      @(negedge clk);
      if (low_strobe || !scl_out) saw_low = 1;
    end
    chk(!saw_low, "R6 no low part while held", saw_low, 0);
    #1 hold = 1'b0;
    n = 1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (low_strobe) break;
      n++;
    end
    chk(n == exp_after, tag, n, exp_after);
  endtask

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    chk({scl_out, low_strobe, high_strobe, data_strobe} == 4'b1000,
        "R1 reset state", {scl_out, low_strobe, high_strobe, data_strobe}, 4'b1000);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(scl_out == 1'b1, "R1 idle while disabled", scl_out, 1);
    #1 enable = 1'b1;
    @(negedge clk);
    chk(low_strobe && !scl_out, "R1 first low cycle after enable",
        {low_strobe, scl_out}, 2'b10);

    cur_req = "R2";
    check_period(3, 3, "R2 standard baud 3");
    set_cfg(2'd0, 5, 0);
    check_period(5, 5, "R2 standard baud 5");

    cur_req = "R3";
    set_cfg(2'd1, 3, 0);
    check_period(6, 3, "R3 fast baud 3");
    set_cfg(2'd1, 1, 0);
    check_period(2, 1, "R3 fast baud 1");

    cur_req = "R4";
    set_cfg(2'd2, 4, 0);
    check_period(4, 4, "R4 mode 2 as standard");
    set_cfg(2'd3, 2, 0);
    check_period(2, 2, "R4 mode 3 as standard");

    cur_req = "R7";
    set_cfg(2'd0, 4, 5);
    check_period(4, 4, "R7 setup unused without stretch");
    stretch_run(7, 9, "R7 stretched high length baud+setup");
    cur_req = "R6";
    set_cfg(2'd0, 4, 0);
    stretch_run(5, 4, "R6 high count restarts after hold");
    set_cfg(2'd1, 2, 3);
    stretch_run(1, 5, "R6 single-cycle hold in fast mode");

    cur_req = "R5";
    set_cfg(2'd0, 0, 0);
    @(negedge clk);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!scl_out || low_strobe || high_strobe || data_strobe) bad++;
    end
    chk(bad == 0, "R5 zero baud stays idle", bad, 0);
    #1 baud = 16'd3;
    @(negedge clk);
    chk(low_strobe && !scl_out, "R5 restart after non-zero baud",
        {low_strobe, scl_out}, 2'b10);

    cur_req = "R10";
    wait_low_start();
    @(negedge clk);
    #1 enable = 1'b0;
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!scl_out || low_strobe || high_strobe || data_strobe) bad++;
    end
    chk(bad == 0, "R10 parked after mid-period disable", bad, 0);
    #1 enable = 1'b1;
    @(negedge clk);
    chk(low_strobe && !scl_out, "R1 fresh low part after re-enable",
        {low_strobe, scl_out}, 2'b10);

    cur_req = "R8";
    check_period(3, 3, "R8 period after re-enable");

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

endmodule